// File: doc/BRIEF.md
# Serial Divider Configuration Port

This block is the configuration front end of a clock synthesizer. A host drives three plain control wires: a serial clock, a serial data line and a load strobe. Bits are gathered in a 15-bit shift register on rising serial-clock edges. The block then moves the word into holding registers. Those registers feed the feedback divider value, the output divider code, a two-bit test selector and a spread-spectrum enable to the rest of the synthesizer.

The block runs on a fast system clock. All three serial wires are treated as already synchronised, level-sampled inputs, and the block finds their edges itself. The strobe has two modes. While it is low, serial edges only shift, and the held configuration stays frozen. Its rising edge commits the shifted word. While it stays high, every serial edge shifts, and the held configuration follows the shift register at once (transparent mode).

A test pin is driven through a four-way selector. It can show a constant low, the bit that is about to leave the shift register, a tap from the feedback divider, or a tap from the synthesized clock. After reset the selector picks the shift-register bit, so the register can be read back straight away. The serial side has no handshake: each detected edge is consumed in the cycle it is seen, and nothing can be stalled.

Top module: `syncfg_top`

## Requirements
- R1: While the strobe is low, each rising edge of the serial clock shifts the data bit into bit 0 of the 15-bit shift register, and the older bits move toward bit 14. The output changes in the system-clock cycle that detects the edge.
- R2: A rising edge of the strobe copies the shift register into the held configuration. Field positions, with bit 14 shifted in first: test select [14:13], output divider code [12:10], feedback value M [9:1] (M8 at bit 9), spread enable [0].
- R3: While the strobe is low, the held configuration never changes, however many serial edges arrive.
- R4: While the strobe is high, each rising serial-clock edge shifts the register and loads the shifted word into the held configuration in the same cycle.
- R5: The test pin follows the test select value as follows: 00 gives constant 0; 01 gives shift register bit 14; 10 gives the feedback-divider tap; 11 gives the output-clock tap.
- R6: Master reset (rst high) acts at once, without waiting for a clock. It sets both the held configuration and the shift register to M=192, divider code 000, spread off and test select 01.
- R7: The out-of-range flag is 1 exactly when the held M is below 120 or above 240. Such a value is still held and presented.
- R8: The divide ratio output decodes the held code: 000→2, 001→4, 010→8, 011→16, 100→1, 101→2, 110→4, 111→8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial wires |
| rst | input | 1 | Master reset, asynchronous, active high |
| sclk | input | 1 | Serial clock level |
| sdata | input | 1 | Serial data bit |
| sload | input | 1 | Load strobe level |
| fb_tap | input | 1 | Feedback divider output tap |
| fout_tap | input | 1 | Synthesized clock tap |
| m_val | output | 9 | Held feedback divider value M |
| n_code | output | 3 | Held output divider code |
| n_ratio | output | 5 | Decoded output divide ratio |
| t_mode | output | 2 | Held test select |
| ssc_en | output | 1 | Held spread-spectrum enable |
| m_out_of_range | output | 1 | Held M is outside 120..240 |
| test_out | output | 1 | Test pin |

## Verification
The hardest case is transparent mode. It needs the strobe to stay high across several serial edges, and a rising strobe edge on its own must first commit the word. The stimulus raises the strobe, checks the committed word, and then shifts several random bits with the strobe still high, comparing the held fields after every edge. It then drops the strobe and shifts more bits to show that the held fields freeze. Random words are mixed with forced M values of 0, 119, 120, 240, 241 and 511 so that both edges of the lock range are reached.

// File: rtl/syncfg_pkg.sv
package syncfg_pkg;
  localparam int M_W    = 9;
  localparam int N_W    = 3;
  localparam int T_W    = 2;
  localparam int R_W    = 5;
  localparam int WORD_W = T_W + N_W + M_W + 1;

  // first field sits in the MSBs: it is the first bit shifted in
  typedef struct packed {
    logic [T_W-1:0] tsel;
    logic [N_W-1:0] ncode;
    logic [M_W-1:0] mval;
    logic           ssc;
  } cfg_word_t;

  typedef enum logic [T_W-1:0] {
    TS_LOW   = 2'b00,
    TS_SHIFT = 2'b01,
    TS_FB    = 2'b10,
    TS_CLK   = 2'b11
  } tsel_e;

  localparam cfg_word_t CFG_DEFAULT = '{tsel: 2'b01, ncode: 3'b000,
                                        mval: 9'd192, ssc: 1'b0};

  // upper code bit picks base 1, otherwise base 2; low bits are a power of two
  function automatic logic [R_W-1:0] ratio_of(input logic [N_W-1:0] c);
    logic [R_W-1:0] base;
    base = c[N_W-1] ? R_W'(1) : R_W'(2);
    return base << c[N_W-2:0];
  endfunction
endpackage

// File: rtl/syncfg_edge.sv
module syncfg_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] lvl_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or posedge rst) begin
      if (rst) lvl_q[i] <= 1'b0;
      else     lvl_q[i] <= lvl[i];
    end
    assign rise[i] = lvl[i] & ~lvl_q[i];
  end
endmodule

// File: rtl/syncfg_shreg.sv
module syncfg_shreg
  import syncfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      shift_en,
  input  logic      din,
  output cfg_word_t word,
  output cfg_word_t word_next,
  output logic      msb
);
  logic [WORD_W-1:0] sr_q;
  logic [WORD_W-1:0] sr_d;

  assign sr_d = shift_en ? {sr_q[WORD_W-2:0], din} : sr_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) sr_q <= WORD_W'(CFG_DEFAULT);
    else     sr_q <= sr_d;
  end

  assign word      = cfg_word_t'(sr_q);
  assign word_next = cfg_word_t'(sr_d);
  assign msb       = sr_q[WORD_W-1];

  // R1
  sr_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(sr_q));
endmodule

// File: rtl/syncfg_hold.sv
module syncfg_hold
  import syncfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load_high,
  input  logic      load_rise,
  input  logic      shift_rise,
  input  cfg_word_t word_next,
  output cfg_word_t cfg
);
  logic upd;

  assign upd = load_high & (load_rise | shift_rise);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)      cfg <= CFG_DEFAULT;
    else if (upd) cfg <= word_next;
  end

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !load_high |=> $stable(cfg));

  // R6
  reset_default_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg == CFG_DEFAULT));
endmodule

// File: rtl/syncfg_testmux.sv
module syncfg_testmux
  import syncfg_pkg::*;
(
  input  logic [T_W-1:0] tsel,
  input  logic           sr_msb,
  input  logic           fb_tap,
  input  logic           fout_tap,
  output logic           tout
);
  always_comb begin
    unique case (tsel_e'(tsel))
      TS_LOW:   tout = 1'b0;
      TS_SHIFT: tout = sr_msb;
      TS_FB:    tout = fb_tap;
      TS_CLK:   tout = fout_tap;
      default:  tout = 1'b0;
    endcase
  end
endmodule

// File: rtl/syncfg_top.sv
module syncfg_top
  import syncfg_pkg::*;
#(
  parameter int M_LOCK_MIN = 120,
  parameter int M_LOCK_MAX = 240
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           sclk,
  input  logic           sdata,
  input  logic           sload,
  input  logic           fb_tap,
  input  logic           fout_tap,
  output logic [M_W-1:0] m_val,
  output logic [N_W-1:0] n_code,
  output logic [R_W-1:0] n_ratio,
  output logic [T_W-1:0] t_mode,
  output logic           ssc_en,
  output logic           m_out_of_range,
  output logic           test_out
);
  localparam logic [M_W-1:0] LO = M_W'(M_LOCK_MIN);
  localparam logic [M_W-1:0] HI = M_W'(M_LOCK_MAX);

  logic [1:0] rise;
  cfg_word_t  sr_word, sr_next, held;
  logic       sr_msb;

  syncfg_edge #(.W(2)) u_edge (
    .clk (clk), .rst (rst), .lvl ({sload, sclk}), .rise (rise)
  );

  syncfg_shreg u_shreg (
    .clk (clk), .rst (rst), .shift_en (rise[0]), .din (sdata),
    .word (sr_word), .word_next (sr_next), .msb (sr_msb)
  );

  syncfg_hold u_hold (
    .clk (clk), .rst (rst), .load_high (sload), .load_rise (rise[1]),
    .shift_rise (rise[0]), .word_next (sr_next), .cfg (held)
  );

  syncfg_testmux u_mux (
    .tsel (held.tsel), .sr_msb (sr_msb), .fb_tap (fb_tap),
    .fout_tap (fout_tap), .tout (test_out)
  );

  assign m_val          = held.mval;
  assign n_code         = held.ncode;
  assign n_ratio        = ratio_of(held.ncode);
  assign t_mode         = held.tsel;
  assign ssc_en         = held.ssc;
  assign m_out_of_range = (held.mval < LO) || (held.mval > HI);

  // R5
  test_low_chk: assert property (@(posedge clk) disable iff (rst)
    (t_mode == 2'b00) |-> !test_out);

  // R8
  ratio_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(n_ratio) == 1);

  // R4
  transp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (sload && $past(sload) && $changed(sr_word)) |-> (held == sr_word));
endmodule

// File: tb/tb_syncfg_top.sv
`timescale 1ns/1ps
module tb_syncfg_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdata = 1'b0, sload = 1'b0, fb_tap = 1'b0, fout_tap = 1'b0;
  logic [8:0] m_val;
  logic [2:0] n_code;
  logic [4:0] n_ratio;
  logic [1:0] t_mode;
  logic       ssc_en, m_out_of_range, test_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [14:0] mdl_sr, mdl_cfg;
  localparam logic [14:0] DEF = {2'b01, 3'b000, 9'd192, 1'b0};

  always #5 clk = ~clk;

  syncfg_top dut (
    .clk (clk), .rst (rst), .sclk (sclk), .sdata (sdata), .sload (sload),
    .fb_tap (fb_tap), .fout_tap (fout_tap), .m_val (m_val), .n_code (n_code),
    .n_ratio (n_ratio), .t_mode (t_mode), .ssc_en (ssc_en),
    .m_out_of_range (m_out_of_range), .test_out (test_out)
  );

  function automatic int exp_ratio(input logic [2:0] c);
    case (c)
      3'd0: return 2;  3'd1: return 4;  3'd2: return 8;  3'd3: return 16;
      3'd4: return 1;  3'd5: return 2;  3'd6: return 4;  default: return 8;
    endcase
  endfunction

  function automatic logic exp_test(input logic [1:0] t, input logic [14:0] sr,
                                    input logic fb, input logic ck);
    case (t)
      2'b00: return 1'b0;
      2'b01: return sr[14];
      2'b10: return fb;
      default: return ck;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [8:0] m;
    m = mdl_cfg[9:1];
    chk({tag, " M"}, m_val, m);
    chk({tag, " N"}, n_code, mdl_cfg[12:10]);
    chk({tag, " T"}, t_mode, mdl_cfg[14:13]);
    chk({tag, " SSC"}, ssc_en, mdl_cfg[0]);
    chk({tag, " R8 ratio"}, n_ratio, exp_ratio(mdl_cfg[12:10]));
    chk({tag, " R7 range"}, m_out_of_range, (m < 120 || m > 240) ? 1 : 0);
    chk({tag, " R5 test"}, test_out,
        exp_test(mdl_cfg[14:13], mdl_sr, fb_tap, fout_tap));
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk); sdata = b; sclk = 1'b1;
    @(negedge clk); sclk = 1'b0;
    @(negedge clk);
    mdl_sr = {mdl_sr[13:0], b};
    if (sload) mdl_cfg = mdl_sr;
  endtask

  task automatic shift_word(input logic [14:0] w);
    for (int i = 14; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic pulse_load();
    @(negedge clk); sload = 1'b1;
    @(negedge clk); sload = 1'b0;
    @(negedge clk);
    mdl_cfg = mdl_sr;
  endtask

  task automatic rand_taps();
    fb_tap = 1'($urandom); fout_tap = 1'($urandom); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [14:0] w;
    logic [8:0]  corner [6];
    corner = '{9'd0, 9'd119, 9'd120, 9'd240, 9'd241, 9'd511};
    void'($urandom(32'd8427));
    mdl_sr = DEF; mdl_cfg = DEF;
    repeat (3) @(negedge clk);
    check_all("R6 reset");
    rst = 1'b0;
    @(negedge clk);
    check_all("R6 after release");

    // readback of the default shift register via test pin (R1, R5)
    for (int i = 0; i < 15; i++) begin
      shift_bit(1'($urandom));
      chk("R1 readback", test_out, mdl_sr[14]);
      chk("R3 shift no change M", m_val, 192);
    end

    // random words plus lock-range corners (R2, R7, R5, R3)
    for (int it = 0; it < 40; it++) begin
      w = 15'($urandom);
      if (it < 6) w[9:1] = corner[it];
      shift_word(w);
      pulse_load();
      rand_taps();
      check_all("R2 load");
      for (int k = 0; k < 1 + (it % 5); k++) shift_bit(1'($urandom));
      rand_taps();
      check_all("R3 held");
    end

    // transparent mode (R4)
    shift_word({2'b00, 3'b011, 9'd200, 1'b1});
    @(negedge clk); sload = 1'b1;
    @(negedge clk); mdl_cfg = mdl_sr;
    check_all("R4 strobe rise");
    for (int k = 0; k < 10; k++) begin
      shift_bit(1'($urandom));
      rand_taps();
      check_all("R4 transparent");
    end
    @(negedge clk); sload = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 4; k++) shift_bit(1'($urandom));
    check_all("R3 after transparent");

    // every divider code (R8)
    for (int c = 0; c < 8; c++) begin
      shift_word({2'b10, 3'(c), 9'd150, 1'b0});
      pulse_load();
      chk("R8 decode", n_ratio, exp_ratio(3'(c)));
    end

    // asynchronous reset in mid-operation (R6)
    shift_word({2'b11, 3'b101, 9'd99, 1'b1});
    pulse_load();
    @(negedge clk); #2 rst = 1'b1; #1;
    mdl_sr = DEF; mdl_cfg = DEF;
    check_all("R6 async");
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check_all("R6 release");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule